// File: doc/BRIEF.md
# Branch and Next-PC Unit

This block computes, in one combinational pass, the address of the next instruction to fetch. It receives the address of the instruction now being executed, the 32-bit instruction word itself, and the two register values that the register file has already read for the two source fields of that word. It returns the next fetch address and a flag that is set whenever that address is not the plain sequential step.

Three kinds of flow are covered. The first is straight-line fetch. The second is the conditional branches: one compares the two operands for equality and one for inequality, and four test the first operand as a signed number against zero. The third is the direct jump, which replaces the low 28 bits of the address with a 26-bit word index taken from the instruction. Branch offsets are counted in whole instructions from the instruction after the branch. A jump keeps the top four address bits of that following instruction, so a jump cannot leave its 256 MiB region.

A fetch stage uses the block between its program-counter register and the instruction memory. A parameter chooses between two separate adders for the sequential and branch targets and one shared adder that takes a pre-incremented offset.

Top module: `nxpc_unit`

## Requirements
- R1: For any opcode (bits 31:26) other than 1, 2, 4, 5, 6 or 7, the next address is the current address plus 4 (wrapping modulo 2^32) and the redirect flag is 0.
- R2: Opcode 4 is taken when the two operands are bit-for-bit equal and is not taken otherwise.
- R3: Opcode 5 is taken when the two operands differ and is not taken when they are equal.
- R4: Opcode 6 is taken when the first operand, read as a signed number, is zero or negative. Opcode 7 is taken when it is strictly positive.
- R5: Under opcode 1, the second register field (bits 20:16) selects the test. The value 0 takes the branch when the first operand is negative, and the value 1 takes it when the operand is zero or positive. Any other value there gives sequential flow.
- R6: A taken branch goes to current address + 4 + 4 × (sign-extended 16-bit offset in bits 15:0), modulo 2^32. Offset 0x7FFF gives the farthest forward target and 0x8000 the farthest backward one. A branch that is not taken goes to current address + 4.
- R7: Opcode 2 goes to {bits 31:28 of (current address + 4), bits 25:0 of the instruction, 2'b00}.
- R8: The redirect flag is 1 for every opcode-2 jump and for every branch whose condition holds, and 0 otherwise.
- R9: The zero-compare branches (opcodes 1, 6, 7) do not depend on the second operand, and the jump depends on neither operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cur_pc | input | 32 | Address of the instruction being executed |
| instr_word | input | 32 | That instruction |
| src_a | input | 32 | Value read for the first source field |
| src_b | input | 32 | Value read for the second source field |
| next_pc | output | 32 | Address of the next instruction to fetch |
| redirect | output | 1 | Set when next_pc is not the sequential step |

## Verification
The block holds no state, so a fault in decode, in the condition logic or in target formation shows at the ports in the same evaluation. A wrong condition shows as a redirect flag that disagrees with the operand signs. A wrong offset scaling or sign extension shows as a target that is shifted or mirrored. A region error in a jump shows only when the incremented address crosses a 256 MiB boundary, which is why boundary addresses and extreme offsets are driven explicitly.

// File: rtl/nxpc_pkg.sv
package nxpc_pkg;

   // instruction classes the unit tells apart
   typedef enum logic [2:0] {
      FLOW_SEQ  = 3'd0,
      FLOW_JUMP = 3'd1,
      FLOW_EQ   = 3'd2,
      FLOW_NE   = 3'd3,
      FLOW_LEZ  = 3'd4,
      FLOW_GTZ  = 3'd5,
      FLOW_LTZ  = 3'd6,
      FLOW_GEZ  = 3'd7
   } flow_e;

   localparam int unsigned OPC_W = 6;
   localparam int unsigned SEL_W = 5;

   localparam logic [OPC_W-1:0] OPC_ZCMP = 6'd1;
   localparam logic [OPC_W-1:0] OPC_JMP  = 6'd2;
   localparam logic [OPC_W-1:0] OPC_EQ   = 6'd4;
   localparam logic [OPC_W-1:0] OPC_NE   = 6'd5;
   localparam logic [OPC_W-1:0] OPC_LEZ  = 6'd6;
   localparam logic [OPC_W-1:0] OPC_GTZ  = 6'd7;

   localparam logic [SEL_W-1:0] SEL_LTZ = 5'd0;
   localparam logic [SEL_W-1:0] SEL_GEZ = 5'd1;

   function automatic logic is_branch(flow_e f);
      return (f != FLOW_SEQ) && (f != FLOW_JUMP);
   endfunction

endpackage

// File: rtl/nxpc_decode.sv
module nxpc_decode
   import nxpc_pkg::*;
#(
   parameter int unsigned XLEN   = 32,
   parameter int unsigned IMM_W  = 16,
   parameter int unsigned JIDX_W = 26
) (
   input  logic [XLEN-1:0]   instr_word,
   output flow_e             flow,
   output logic [IMM_W-1:0]  br_imm,
   output logic [JIDX_W-1:0] jmp_idx
);

   localparam int unsigned OPC_LSB = XLEN - OPC_W;
   localparam int unsigned SEL_LSB = IMM_W;

   logic [OPC_W-1:0] opc;
   logic [SEL_W-1:0] sel;

   assign opc     = instr_word[OPC_LSB +: OPC_W];
   assign sel     = instr_word[SEL_LSB +: SEL_W];
   assign br_imm  = instr_word[IMM_W-1:0];
   assign jmp_idx = instr_word[JIDX_W-1:0];

   always_comb begin
      flow = FLOW_SEQ;
      unique case (opc)
         OPC_JMP:  flow = FLOW_JUMP;
         OPC_EQ:   flow = FLOW_EQ;
         OPC_NE:   flow = FLOW_NE;
         OPC_LEZ:  flow = FLOW_LEZ;
         OPC_GTZ:  flow = FLOW_GTZ;
         OPC_ZCMP: begin
            if (sel == SEL_LTZ)      flow = FLOW_LTZ;
            else if (sel == SEL_GEZ) flow = FLOW_GEZ;
            else                     flow = FLOW_SEQ;
         end
         default:  flow = FLOW_SEQ;
      endcase
   end

   // R5: the shared opcode never decodes to a zero test unless the selector is 0 or 1
   always_comb begin
      a_r5_zcmp_select: assert (!((flow == FLOW_LTZ || flow == FLOW_GEZ) && sel > SEL_GEZ))
         else $error("zero-compare class decoded from illegal selector");
   end

endmodule

// File: rtl/nxpc_cond.sv
module nxpc_cond
   import nxpc_pkg::*;
#(
   parameter int unsigned XLEN = 32
) (
   input  flow_e           flow,
   input  logic [XLEN-1:0] src_a,
   input  logic [XLEN-1:0] src_b,
   output logic            take
);

   logic a_zero, a_neg, same;

   assign a_zero = (src_a == '0);
   assign a_neg  = src_a[XLEN-1];
   assign same   = (src_a == src_b);

   always_comb begin
      unique case (flow)
         FLOW_JUMP: take = 1'b1;
         FLOW_EQ:   take = same;
         FLOW_NE:   take = !same;
         FLOW_LEZ:  take = a_neg || a_zero;
         FLOW_GTZ:  take = !a_neg && !a_zero;
         FLOW_LTZ:  take = a_neg;
         FLOW_GEZ:  take = !a_neg;
         default:   take = 1'b0;
      endcase
   end

   // R1: sequential class never redirects; R4/R5: the signed zero tests agree with the sign of src_a
   always_comb begin
      a_r1_seq_never_taken: assert (!(flow == FLOW_SEQ && take))
         else $error("sequential flow reported taken");
      a_r4_gtz_positive: assert (!(flow == FLOW_GTZ && take && $signed(src_a) <= 0))
         else $error("greater-than-zero taken on non-positive operand");
      a_r5_ltz_negative: assert (!(flow == FLOW_LTZ && take && $signed(src_a) >= 0))
         else $error("less-than-zero taken on non-negative operand");
   end

endmodule

// File: rtl/nxpc_target.sv
module nxpc_target
   import nxpc_pkg::*;
#(
   parameter int unsigned XLEN         = 32,
   parameter int unsigned IMM_W        = 16,
   parameter int unsigned JIDX_W       = 26,
   parameter bit          SHARED_ADDER = 1'b0
) (
   input  logic [XLEN-1:0]   cur_pc,
   input  flow_e             flow,
   input  logic              take,
   input  logic [IMM_W-1:0]  br_imm,
   input  logic [JIDX_W-1:0] jmp_idx,
   output logic [XLEN-1:0]   next_pc
);

   localparam int unsigned REGION_W = XLEN - JIDX_W - 2;
   localparam int unsigned EXT_W    = XLEN - IMM_W - 2;
   localparam logic [XLEN-1:0] STEP = XLEN'(4);

   logic            br_go;
   logic [XLEN-1:0] jmp_tgt;

   assign br_go = take && is_branch(flow);

   generate
      if (SHARED_ADDER) begin : g_shared
         // one wide adder; the offset is incremented on a narrow field first
         logic [IMM_W:0]  imm_inc;
         logic [XLEN-1:0] addend;
         logic [XLEN-1:0] sum;

         assign imm_inc = {br_imm[IMM_W-1], br_imm} + 1'b1;
         assign addend  = br_go ? {{(EXT_W-1){imm_inc[IMM_W]}}, imm_inc, 2'b00} : STEP;
         assign sum     = cur_pc + addend;
         assign jmp_tgt = {sum[XLEN-1 -: REGION_W], jmp_idx, 2'b00};

         always_comb begin
            if (flow == FLOW_JUMP) next_pc = jmp_tgt;
            else                   next_pc = sum;
         end
      end else begin : g_split
         // sequential and branch targets formed side by side
         logic [XLEN-1:0] seq_pc;
         logic [XLEN-1:0] br_off;
         logic [XLEN-1:0] br_tgt;

         assign seq_pc  = cur_pc + STEP;
         assign br_off  = {{EXT_W{br_imm[IMM_W-1]}}, br_imm, 2'b00};
         assign br_tgt  = seq_pc + br_off;
         assign jmp_tgt = {seq_pc[XLEN-1 -: REGION_W], jmp_idx, 2'b00};

         always_comb begin
            if (flow == FLOW_JUMP) next_pc = jmp_tgt;
            else if (br_go)        next_pc = br_tgt;
            else                   next_pc = seq_pc;
         end
      end
   endgenerate

endmodule

// File: rtl/nxpc_unit.sv
module nxpc_unit
   import nxpc_pkg::*;
#(
   parameter int unsigned XLEN         = 32,
   parameter int unsigned IMM_W        = 16,
   parameter int unsigned JIDX_W       = 26,
   parameter bit          SHARED_ADDER = 1'b0
) (
   input  logic [XLEN-1:0] cur_pc,
   input  logic [XLEN-1:0] instr_word,
   input  logic [XLEN-1:0] src_a,
   input  logic [XLEN-1:0] src_b,
   output logic [XLEN-1:0] next_pc,
   output logic            redirect
);

   localparam int unsigned REGION_W = XLEN - JIDX_W - 2;

   generate
      if (XLEN != OPC_W + JIDX_W) begin : g_bad_jidx
         $error("jump index plus opcode must fill the instruction word");
      end
      if (IMM_W + SEL_W + SEL_W + OPC_W != XLEN) begin : g_bad_imm
         $error("branch fields must fill the instruction word");
      end
      if (REGION_W < 1) begin : g_bad_region
         $error("no region bits left for jumps");
      end
   endgenerate

   flow_e              flow;
   logic [IMM_W-1:0]   br_imm;
   logic [JIDX_W-1:0]  jmp_idx;
   logic               take;

   nxpc_decode #(.XLEN(XLEN), .IMM_W(IMM_W), .JIDX_W(JIDX_W)) u_decode (
      .instr_word (instr_word),
      .flow       (flow),
      .br_imm     (br_imm),
      .jmp_idx    (jmp_idx)
   );

   nxpc_cond #(.XLEN(XLEN)) u_cond (
      .flow  (flow),
      .src_a (src_a),
      .src_b (src_b),
      .take  (take)
   );

   nxpc_target #(
      .XLEN(XLEN), .IMM_W(IMM_W), .JIDX_W(JIDX_W), .SHARED_ADDER(SHARED_ADDER)
   ) u_target (
      .cur_pc  (cur_pc),
      .flow    (flow),
      .take    (take),
      .br_imm  (br_imm),
      .jmp_idx (jmp_idx),
      .next_pc (next_pc)
   );

   assign redirect = take;

   always_comb begin
      // R8: without redirect the fetch simply steps one instruction
      a_r8_idle_steps: assert (redirect || next_pc == cur_pc + XLEN'(4))
         else $error("no redirect but next_pc is not the sequential step");
      // R7: jumps are word aligned and stay in the region of the following instruction
      a_r7_jump_region: assert (flow != FLOW_JUMP ||
                                (next_pc[1:0] == 2'b00 &&
                                 next_pc[XLEN-1 -: REGION_W] == (cur_pc + XLEN'(4)) >> (XLEN - REGION_W)))
         else $error("jump left its region or lost alignment");
      // R6: branch targets keep the byte alignment of the current address
      a_r6_branch_align: assert (!is_branch(flow) || next_pc[1:0] == cur_pc[1:0])
         else $error("branch target changed the low address bits");
   end

endmodule

// File: tb/nxpc_unit_bench.sv
module nxpc_unit_bench;

   localparam int CLK_PERIOD = 10;
   localparam int NVEC       = 29;

   typedef struct packed {
      logic [31:0] pc;
      logic [31:0] ins;
      logic [31:0] a;
      logic [31:0] b;
      logic [31:0] nxt;
      logic        tk;
      logic [7:0]  req;
   } vec_t;

   // pc, instruction, src_a, src_b, expected next, expected redirect, requirement
   localparam vec_t VEC [NVEC] = '{
      '{32'h0000_1000, 32'h0232_4021, 32'h1,         32'h2,         32'h0000_1004, 1'b0, 8'd1}, // R1 other opcode
      '{32'h0000_1000, 32'h1000_0003, 32'h5,         32'h5,         32'h0000_1010, 1'b1, 8'd2}, // R2 equal, forward
      '{32'h0000_1000, 32'h1000_0003, 32'h5,         32'h6,         32'h0000_1004, 1'b0, 8'd2}, // R2 unequal
      '{32'h0000_1000, 32'h1000_FFFE, 32'h9,         32'h9,         32'h0000_0FFC, 1'b1, 8'd6}, // R6 backward
      '{32'h0000_2000, 32'h1400_0010, 32'h1,         32'h2,         32'h0000_2044, 1'b1, 8'd3}, // R3 differ
      '{32'h0000_2000, 32'h1400_0010, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_2004, 1'b0, 8'd3}, // R3 equal
      '{32'h0000_3000, 32'h1800_0004, 32'h8000_0000, 32'h0,         32'h0000_3014, 1'b1, 8'd4}, // R4 le negative
      '{32'h0000_3000, 32'h1800_0004, 32'h0,         32'h0,         32'h0000_3014, 1'b1, 8'd4}, // R4 le zero
      '{32'h0000_3000, 32'h1800_0004, 32'h1,         32'h0,         32'h0000_3004, 1'b0, 8'd4}, // R4 le positive
      '{32'h0000_3000, 32'h1C00_0004, 32'h7FFF_FFFF, 32'h0,         32'h0000_3014, 1'b1, 8'd4}, // R4 gt positive
      '{32'h0000_3000, 32'h1C00_0004, 32'h0,         32'h0,         32'h0000_3004, 1'b0, 8'd4}, // R4 gt zero
      '{32'h0000_3000, 32'h1C00_0004, 32'hFFFF_FFFF, 32'h0,         32'h0000_3004, 1'b0, 8'd4}, // R4 gt negative
      '{32'h0000_3000, 32'h0400_0004, 32'hFFFF_FFF0, 32'h0,         32'h0000_3014, 1'b1, 8'd5}, // R5 lt negative
      '{32'h0000_3000, 32'h0400_0004, 32'h0,         32'h0,         32'h0000_3004, 1'b0, 8'd5}, // R5 lt zero
      '{32'h0000_3000, 32'h0400_0004, 32'h5,         32'h0,         32'h0000_3004, 1'b0, 8'd5}, // R5 lt positive
      '{32'h0000_3000, 32'h0401_0004, 32'h0,         32'h0,         32'h0000_3014, 1'b1, 8'd5}, // R5 ge zero
      '{32'h0000_3000, 32'h0401_0004, 32'h5,         32'h0,         32'h0000_3014, 1'b1, 8'd5}, // R5 ge positive
      '{32'h0000_3000, 32'h0401_0004, 32'h8000_0001, 32'h0,         32'h0000_3004, 1'b0, 8'd5}, // R5 ge negative
      '{32'h0000_3000, 32'h0402_0004, 32'h0,         32'h0,         32'h0000_3004, 1'b0, 8'd5}, // R5 other selector
      '{32'h4000_0000, 32'h0800_0100, 32'h0,         32'h0,         32'h4000_0400, 1'b1, 8'd7}, // R7 in region
      '{32'h4FFF_FFFC, 32'h0BFF_FFFF, 32'h0,         32'h0,         32'h5FFF_FFFC, 1'b1, 8'd7}, // R7 region crossing
      '{32'hF000_0010, 32'h0800_0001, 32'h0,         32'h0,         32'hF000_0004, 1'b1, 8'd7}, // R7 top region
      '{32'h0001_0000, 32'h1000_7FFF, 32'h3,         32'h3,         32'h0003_0000, 1'b1, 8'd6}, // R6 max forward
      '{32'h0001_0000, 32'h1000_8000, 32'h3,         32'h3,         32'hFFFF_0004, 1'b1, 8'd6}, // R6 max backward wraps
      '{32'h0000_1000, 32'h1000_8000, 32'h3,         32'h4,         32'h0000_1004, 1'b0, 8'd6}, // R6 not taken
      '{32'hFFFF_FFFC, 32'h0000_0000, 32'h0,         32'h0,         32'h0000_0000, 1'b0, 8'd1}, // R1 wrap
      '{32'h0000_0040, 32'h0C00_0010, 32'h0,         32'h0,         32'h0000_0044, 1'b0, 8'd1}, // R1 opcode 3
      '{32'h0000_3000, 32'h1800_0004, 32'h0,         32'hDEAD_BEEF, 32'h0000_3014, 1'b1, 8'd9}, // R9 b ignored
      '{32'h4000_0000, 32'h0800_0100, 32'h1234_5678, 32'h8765_4321, 32'h4000_0400, 1'b1, 8'd9}  // R9 jump operands
   };

   logic        clk;
   logic        rst_n;
   logic [31:0] cur_pc, instr_word, src_a, src_b;
   logic [31:0] next_pc;
   logic        redirect;

   int n_cmp;
   int n_bad;
   int cycles;

   nxpc_unit u_nxpc_unit (
      .cur_pc     (cur_pc),
      .instr_word (instr_word),
      .src_a      (src_a),
      .src_b      (src_b),
      .next_pc    (next_pc),
      .redirect   (redirect)
   );

   initial clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic drive(input logic [31:0] pc, ins, a, b);
      @(negedge clk);
      cur_pc     = pc;
      instr_word = ins;
      src_a      = a;
      src_b      = b;
      #(CLK_PERIOD/4);
   endtask

   task automatic compare(input string tag, input logic [31:0] exp_nxt, input logic exp_tk);
      n_cmp++;
      if (next_pc !== exp_nxt || redirect !== exp_tk) begin
         n_bad++;
         $display("FAIL %s: next_pc=%h redirect=%b expected next_pc=%h redirect=%b",
                  tag, next_pc, redirect, exp_nxt, exp_tk);
      end
   endtask

   initial begin
      cycles = 0;
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 20000) begin
            n_bad++;
            $display("FAIL watchdog: run exceeded %0d cycles, expected completion", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
         end
      end
   end

   initial begin
      n_cmp      = 0;
      n_bad      = 0;
      rst_n      = 1'b0;
      cur_pc     = '0;
      instr_word = '0;
      src_a      = '0;
      src_b      = '0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;

      // reset-time state: all-zero inputs are a plain step (R1)
      #(CLK_PERIOD/4);
      compare("R1 reset inputs", 32'h0000_0004, 1'b0);

      for (int i = 0; i < NVEC; i++) begin
         drive(VEC[i].pc, VEC[i].ins, VEC[i].a, VEC[i].b);
         compare($sformatf("R%0d vector %0d", VEC[i].req, i), VEC[i].nxt, VEC[i].tk);
      end

      // R8: redirect follows the condition as operands change under a fixed branch
      drive(32'h0000_8000, 32'h1400_0002, 32'h7, 32'h7);
      compare("R8 bne equal", 32'h0000_8004, 1'b0);
      drive(32'h0000_8000, 32'h1400_0002, 32'h7, 32'h8);
      compare("R8 bne differ", 32'h0000_800C, 1'b1);

      // R9: second operand swept under a less-than-zero test leaves result unchanged
      for (int k = 0; k < 4; k++) begin
         drive(32'h0000_0100, 32'h0400_FFFF, 32'hFFFF_FFFF, 32'h1 << (k * 8));
         compare("R9 ltz sweep", 32'h0000_0100, 1'b1);
      end

      // R2: operands differing only in the sign bit
      drive(32'h0000_0200, 32'h1000_0001, 32'h8000_0000, 32'h0000_0000);
      compare("R2 sign-bit differ", 32'h0000_0204, 1'b0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule